// File: doc/BRIEF.md
# PCI Type-0 Configuration Header

This block holds the 64-byte type-0 configuration header of a PCI function. It answers configuration reads and writes that arrive on a small request stream. It also keeps up to six base address registers and compares each bus address against them, so the target logic beside it knows which region an incoming memory or I/O transaction belongs to. The identification fields are instance parameters. The command register, status register, latency timer, cache line size, interrupt line and the base address registers are writable state. The command enables, the status flags and the cache line size are exported as plain pins for the neighbouring master, target and parity logic.

Each base address register is described by one 32-bit parameter. Its run of leading ones selects the upper bits that software may write, which sets the region size. Its low nibble is returned unchanged on reads, and bit 0 of that nibble selects I/O (1) or memory (0). A count parameter keeps the first N registers, counting up from register 0. The others read as zero, ignore writes and never hit. A host-bridge parameter holds the master enable bit high.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A claimed read returns its data one cycle later on the response side. That response holds steady while `rsp_ready` is low, and during that time `req_ready` is low, so no further request is taken. Writes and unclaimed requests are taken without any response.

Top module: `pci_cfg_space`

## Requirements
- R1: Reads return the parameter fields at these dword indices (`req_dw` = byte offset / 4): 0 = {device ID, vendor ID}; 2 = {class code, revision ID}; 3 = {8'h00, 8'h00 header type, latency timer, cache line size}; 11 = {subsystem ID, subsystem vendor ID}; 15 = {max latency, min grant, interrupt pin, interrupt line}. Indices 10, 12, 13 and 14 read zero.
- R2: A request is claimed only when `req_sel` is 1 and `req_cmd` is 4'b1010 (read) or 4'b1011 (write). Any other code, or `req_sel` = 0, is accepted but produces no response and changes no register.
- R3: `req_be[k]` (active high) enables byte lane k, which is bits 8k+7..8k of `req_wdata`. A write leaves every disabled lane of its target register unchanged.
- R4: The command register is the low half of dword 1. Only bits 0 (I/O enable), 1 (memory enable), 2 (master enable), 4 (write-and-invalidate enable), 6 (parity error response) and 8 (system error enable) are writable, so writing all ones reads back 16'h0157. Those bits drive `cmd_io_en`, `cmd_mem_en`, `cmd_mst_en`, `cmd_mwi_en`, `cmd_perr_en` and `cmd_serr_en`.
- R5: With `HOST_BRIDGE` = 1, the master enable bit reads 1 and `cmd_mst_en` is 1 from reset onwards, whatever is written.
- R6: `stat_set[k]` sets status flag k on the next edge. Flags 0 to 5 map to status bits 8, 11, 12, 13, 14 and 15 (dword 1 bits 24, 27 to 31) and to `stat_bits[k]`. Writing a 1 to a flag's bit with lane 3 enabled clears that flag, and a set on the same edge wins over the clear.
- R7: Cache line size (dword 3 lane 0), latency timer (dword 3 lane 1) and interrupt line (dword 15 lane 0) are 8-bit read/write registers. `cache_line` shows the cache line size.
- R8: Base address register i sits at dword 4+i. Writable bits are the leading-ones run of `BAR_CFG[i]` excluding bits 3..0, and bits 3..0 read as `BAR_CFG[i][3:0]`.
- R9: Base address registers i >= `NUM_BARS` read zero, ignore writes and keep `bar_hit[i]` at 0.
- R10: A memory BAR (`BAR_CFG[i][0]` = 0) drives `bar_hit[i]` high, combinationally, when `cmd_mem_en` is 1, `dec_cmd` is one of 0110, 0111, 1100, 1110, 1111, and `dec_addr` equals the register on its writable bits.
- R11: An I/O BAR (`BAR_CFG[i][0]` = 1) drives `bar_hit[i]` high when `cmd_io_en` is 1, `dec_cmd` is 0010 or 0011, and the writable bits match.
- R12: A claimed read's data appears with `rsp_valid` on the edge after acceptance and stays stable while `rsp_ready` is 0. `req_ready` equals `!rsp_valid || rsp_ready`.
- R13: After reset, all writable registers and status flags are zero, `rsp_valid` is 0 and no `bar_hit` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this edge |
| req_cmd | input | 4 | Bus command code of the request |
| req_sel | input | 1 | Init-select for this function |
| req_dw | input | 4 | Dword index inside the header |
| req_be | input | 4 | Byte lane enables, active high |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 32 | Read data |
| dec_cmd | input | 4 | Command of the transaction being decoded |
| dec_addr | input | 32 | Address of the transaction being decoded |
| bar_hit | output | 6 | One match flag per base address register |
| stat_set | input | 6 | Status flag set pulses |
| cmd_io_en | output | 1 | I/O space enable |
| cmd_mem_en | output | 1 | Memory space enable |
| cmd_mst_en | output | 1 | Bus master enable |
| cmd_mwi_en | output | 1 | Write-and-invalidate enable |
| cmd_perr_en | output | 1 | Parity error response enable |
| cmd_serr_en | output | 1 | System error enable |
| stat_bits | output | 6 | Status flags, order as in R6 |
| cache_line | output | 8 | Cache line size register |

## Verification
Every one of the 16 command codes is tried with init-select both low and high, on reads and on writes. This shows that only the two configuration codes with select high are claimed, and that an unclaimed write leaves the register unchanged. All 16 byte-enable patterns are written to a register with two writable lanes and to a base address register whose writable bits span two lanes. This separates lane gating from the per-bit writable mask. The decode sweep crosses all 16 transaction codes with the four enable combinations and with addresses inside and just outside each region, which separates the memory and I/O gating from the masked compare. A stalled response and a same-edge set and clear of a status flag cover the ordering cases.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int unsigned MAX_BARS = 6;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
  localparam logic [15:0] CMD_WMASK = 16'h0157;

  // Leading-ones run of a BAR description word
  function automatic logic [31:0] lead_mask(input logic [31:0] p);
    logic [31:0] m;
    logic run;
    run = 1'b1;
    for (int i = 31; i >= 0; i--) begin
      run  = run & p[i];
      m[i] = run;
    end
    return m;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic is_mem_cmd(input logic [3:0] c);
    return (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) ||
           (c == 4'b1110) || (c == 4'b1111);
  endfunction

  function automatic logic is_io_cmd(input logic [3:0] c);
    return (c == 4'b0010) || (c == 4'b0011);
  endfunction
endpackage

// File: rtl/pcfg_bar.sv
module pcfg_bar #(
  parameter logic [31:0] CFG = 32'hFF00_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic [31:0] dec_addr,
  input  logic        dec_mem,
  input  logic        dec_io,
  input  logic        mem_en,
  input  logic        io_en,
  output logic [31:0] rd_data,
  output logic        hit
);
  import pcfg_pkg::*;

  localparam logic [31:0] MASK  = lead_mask(CFG) & 32'hFFFF_FFF0;
  localparam logic        IS_IO = CFG[0];

  logic [31:0] base_q;
  logic [31:0] lm;
  logic        space_ok;

  assign lm = lane_mask(be);

  // R8: only the leading-ones bits hold state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      base_q <= '0;
    else if (wr_en)
      base_q <= ((base_q & ~lm) | (wdata & lm)) & MASK;
  end

  assign rd_data = base_q | {28'h0, CFG[3:0]};

  // R10 / R11: space gating, then masked compare
  generate
    if (IS_IO) begin : g_io
      assign space_ok = io_en & dec_io;
    end else begin : g_mem
      assign space_ok = mem_en & dec_mem;
    end
  endgenerate

  assign hit = (MASK != 32'h0) && space_ok && (((dec_addr ^ base_q) & MASK) == 32'h0);

  AST_BASE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_q)) else $error("base changed without write"); // R8
endmodule

// File: rtl/pcfg_ctrl.sv
module pcfg_ctrl #(
  parameter bit HOST_BRIDGE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cmdstat,
  input  logic        wr_lines,
  input  logic        wr_irq,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic [5:0]  stat_set,
  output logic [15:0] cmd_bits,
  output logic [5:0]  stat_bits,
  output logic [7:0]  cache_line,
  output logic [7:0]  lat_timer,
  output logic [7:0]  irq_line
);
  import pcfg_pkg::*;

  logic [15:0] cmd_q;
  logic [5:0]  stat_q;
  logic [5:0]  clr;
  logic [31:0] lm;
  logic        unused_bits;

  assign lm = lane_mask(be);
  assign unused_bits = ^{wdata[23:16], wdata[26:25], be[2]};

  // R4: command register, writable bits only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cmd_q <= '0;
    else if (wr_cmdstat)
      cmd_q <= ((cmd_q & ~lm[15:0]) | (wdata[15:0] & lm[15:0])) & CMD_WMASK;
  end

  // R5: host bridge holds master enable
  assign cmd_bits = cmd_q | (HOST_BRIDGE ? 16'h0004 : 16'h0000);

  // R6: all status flags live in lane 3; set wins over clear
  assign clr = (wr_cmdstat && be[3]) ?
               {wdata[31], wdata[30], wdata[29], wdata[28], wdata[27], wdata[24]} : 6'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stat_q <= '0;
    else
      stat_q <= (stat_q & ~clr) | stat_set;
  end
  assign stat_bits = stat_q;

  // R7: byte registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache_line <= '0;
      lat_timer  <= '0;
      irq_line   <= '0;
    end else begin
      if (wr_lines && be[0]) cache_line <= wdata[7:0];
      if (wr_lines && be[1]) lat_timer  <= wdata[15:8];
      if (wr_irq   && be[0]) irq_line   <= wdata[7:0];
    end
  end

  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmdstat |=> $stable(cmd_q)) else $error("command changed without write"); // R4
  AST_STAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_set) |=> ((stat_q & $past(stat_set)) == $past(stat_set))) else $error("set lost"); // R6
endmodule

// File: rtl/pci_cfg_space.sv
module pci_cfg_space #(
  parameter int unsigned  NUM_BARS    = 1,
  parameter logic [5:0][31:0] BAR_CFG = {6{32'hFF00_0000}},
  parameter logic [15:0]  DEVICE_ID   = 16'h0001,
  parameter logic [15:0]  VENDOR_ID   = 16'h0001,
  parameter logic [23:0]  CLASS_CODE  = 24'hFF0000,
  parameter logic [7:0]   REVISION_ID = 8'h01,
  parameter logic [15:0]  SUBSYS_ID   = 16'h0000,
  parameter logic [15:0]  SUBSYS_VID  = 16'h0000,
  parameter logic [7:0]   MIN_GNT     = 8'h00,
  parameter logic [7:0]   MAX_LAT     = 8'h00,
  parameter logic [7:0]   INT_PIN     = 8'h01,
  parameter bit           HOST_BRIDGE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [3:0]  req_cmd,
  input  logic        req_sel,
  input  logic [3:0]  req_dw,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data,
  input  logic [3:0]  dec_cmd,
  input  logic [31:0] dec_addr,
  output logic [5:0]  bar_hit,
  input  logic [5:0]  stat_set,
  output logic        cmd_io_en,
  output logic        cmd_mem_en,
  output logic        cmd_mst_en,
  output logic        cmd_mwi_en,
  output logic        cmd_perr_en,
  output logic        cmd_serr_en,
  output logic [5:0]  stat_bits,
  output logic [7:0]  cache_line
);
  import pcfg_pkg::*;

  logic        accept, rd_claim, wr_claim;
  logic [15:0] cmd_bits;
  logic [7:0]  lat_timer, irq_line;
  logic [15:0] stat16;
  logic [31:0] rd_word;
  logic [31:0] bar_rd [MAX_BARS];
  logic        dec_mem, dec_io;

  // R12 / R2: acceptance and claim
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rd_claim  = accept && req_sel && (req_cmd == CMD_CFG_RD);
  assign wr_claim  = accept && req_sel && (req_cmd == CMD_CFG_WR);

  pcfg_ctrl #(.HOST_BRIDGE(HOST_BRIDGE)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_cmdstat (wr_claim && (req_dw == 4'd1)),
    .wr_lines   (wr_claim && (req_dw == 4'd3)),
    .wr_irq     (wr_claim && (req_dw == 4'd15)),
    .be         (req_be),
    .wdata      (req_wdata),
    .stat_set   (stat_set),
    .cmd_bits   (cmd_bits),
    .stat_bits  (stat_bits),
    .cache_line (cache_line),
    .lat_timer  (lat_timer),
    .irq_line   (irq_line)
  );

  assign cmd_io_en   = cmd_bits[0];
  assign cmd_mem_en  = cmd_bits[1];
  assign cmd_mst_en  = cmd_bits[2];
  assign cmd_mwi_en  = cmd_bits[4];
  assign cmd_perr_en = cmd_bits[6];
  assign cmd_serr_en = cmd_bits[8];

  assign dec_mem = is_mem_cmd(dec_cmd);
  assign dec_io  = is_io_cmd(dec_cmd);

  // R8 / R9: present BARs counted up from 0, the rest tied off
  generate
    for (genvar i = 0; i < MAX_BARS; i++) begin : g_bar
      if (i < NUM_BARS) begin : g_on
        pcfg_bar #(.CFG(BAR_CFG[i])) u_bar (
          .clk      (clk),
          .rst_n    (rst_n),
          .wr_en    (wr_claim && (req_dw == 4'(4 + i))),
          .be       (req_be),
          .wdata    (req_wdata),
          .dec_addr (dec_addr),
          .dec_mem  (dec_mem),
          .dec_io   (dec_io),
          .mem_en   (cmd_mem_en),
          .io_en    (cmd_io_en),
          .rd_data  (bar_rd[i]),
          .hit      (bar_hit[i])
        );
      end else begin : g_off
        assign bar_rd[i]  = 32'h0;
        assign bar_hit[i] = 1'b0;
      end
    end
  endgenerate

  assign stat16 = {stat_bits[5:1], 2'b00, stat_bits[0], 8'h00};

  // R1: header read multiplexer
  always_comb begin
    case (req_dw)
      4'd0:    rd_word = {DEVICE_ID, VENDOR_ID};
      4'd1:    rd_word = {stat16, cmd_bits};
      4'd2:    rd_word = {CLASS_CODE, REVISION_ID};
      4'd3:    rd_word = {16'h0000, lat_timer, cache_line};
      4'd4:    rd_word = bar_rd[0];
      4'd5:    rd_word = bar_rd[1];
      4'd6:    rd_word = bar_rd[2];
      4'd7:    rd_word = bar_rd[3];
      4'd8:    rd_word = bar_rd[4];
      4'd9:    rd_word = bar_rd[5];
      4'd11:   rd_word = {SUBSYS_ID, SUBSYS_VID};
      4'd15:   rd_word = {MAX_LAT, MIN_GNT, INT_PIN, irq_line};
      default: rd_word = 32'h0;
    endcase
  end

  // R12: one-entry response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_claim) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)) else $error("response dropped"); // R12
  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(rd_claim)) else $error("response without read"); // R2
endmodule

// File: tb/tb_pci_cfg_space.sv
`timescale 1ns/1ps
module tb_pci_cfg_space;
  localparam logic [5:0][31:0] BARS = {32'hFF00_0000, 32'hFF00_0000, 32'hFF00_0000,
                                       32'hFFF0_0008, 32'hFFFF_FF01, 32'hFF00_0000};
  localparam logic [15:0] DEV = 16'h1234, VEN = 16'hABCD, SID = 16'h7788, SVID = 16'h99AA;
  localparam logic [23:0] CLS = 24'h0C0330;
  localparam logic [7:0]  REV = 8'h5A, MGNT = 8'h11, MLAT = 8'h22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_sel = 0, rsp_ready = 1;
  logic [3:0] req_cmd = 0, req_dw = 0, req_be = 0, dec_cmd = 0;
  logic [31:0] req_wdata = 0, dec_addr = 0;
  logic [5:0] stat_set = 0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic [5:0] bar_hit, stat_bits;
  logic io_en, mem_en, mst_en, mwi_en, perr_en, serr_en;
  logic [7:0] cache_line;

  logic hb_req_ready, hb_rsp_valid;
  logic [31:0] hb_rsp_data;
  logic [5:0] hb_bar_hit, hb_stat;
  logic hb_io, hb_mem, hb_mst, hb_mwi, hb_perr, hb_serr;
  logic [7:0] hb_cache;

  pci_cfg_space #(.NUM_BARS(3), .BAR_CFG(BARS), .DEVICE_ID(DEV), .VENDOR_ID(VEN),
    .CLASS_CODE(CLS), .REVISION_ID(REV), .SUBSYS_ID(SID), .SUBSYS_VID(SVID),
    .MIN_GNT(MGNT), .MAX_LAT(MLAT), .INT_PIN(8'h01), .HOST_BRIDGE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_sel(req_sel), .req_dw(req_dw), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .dec_cmd(dec_cmd), .dec_addr(dec_addr), .bar_hit(bar_hit),
    .stat_set(stat_set), .cmd_io_en(io_en), .cmd_mem_en(mem_en), .cmd_mst_en(mst_en),
    .cmd_mwi_en(mwi_en), .cmd_perr_en(perr_en), .cmd_serr_en(serr_en),
    .stat_bits(stat_bits), .cache_line(cache_line));

  pci_cfg_space #(.HOST_BRIDGE(1'b1)) dut_hb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(hb_req_ready),
    .req_cmd(req_cmd), .req_sel(req_sel), .req_dw(req_dw), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(hb_rsp_valid), .rsp_ready(1'b1),
    .rsp_data(hb_rsp_data), .dec_cmd(dec_cmd), .dec_addr(dec_addr), .bar_hit(hb_bar_hit),
    .stat_set(6'h0), .cmd_io_en(hb_io), .cmd_mem_en(hb_mem), .cmd_mst_en(hb_mst),
    .cmd_mwi_en(hb_mwi), .cmd_perr_en(hb_perr), .cmd_serr_en(hb_serr),
    .stat_bits(hb_stat), .cache_line(hb_cache));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] hb_d;
  logic [31:0] bases [3];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [3:0] c, input logic s, input logic [3:0] dw,
                        input logic [3:0] be, input logic [31:0] wd,
                        output logic got, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_cmd = c; req_sel = s; req_dw = dw; req_be = be; req_wdata = wd;
    @(negedge clk);
    got = rsp_valid; d = rsp_data; hb_d = hb_rsp_data;
    req_valid = 0;
  endtask

  task automatic rd(input logic [3:0] dw, output logic [31:0] d);
    logic g;
    access(4'b1010, 1'b1, dw, 4'hF, 32'h0, g, d);
    chk(g == 1'b1, "R12 read response", {31'h0, g}, 32'h1);
  endtask

  task automatic wr(input logic [3:0] dw, input logic [3:0] be, input logic [31:0] wd);
    logic g;
    logic [31:0] d;
    access(4'b1011, 1'b1, dw, be, wd, g, d);
  endtask

  function automatic logic [31:0] bmask(input logic [31:0] p);
    int n = 0;
    while (n < 32 && p[31-n]) n++;
    if (n == 0) return 32'h0;
    return (32'hFFFF_FFFF << (32 - n)) & 32'hFFFF_FFF0;
  endfunction

  function automatic logic [31:0] lanes(input logic [3:0] be);
    logic [31:0] m = 0;
    for (int k = 0; k < 4; k++) if (be[k]) m = m | (32'hFF << (8*k));
    return m;
  endfunction

  function automatic bit exp_hit(input int i, input int c, input logic [31:0] a,
                                 input bit men, input bit ien);
    logic [31:0] m;
    bit cls;
    if (i >= 3) return 0;
    m = bmask(BARS[i]);
    if (BARS[i][0]) cls = ien && (c == 2 || c == 3);
    else cls = men && (c == 6 || c == 7 || c == 12 || c == 14 || c == 15);
    return cls && (m != 0) && ((a & m) == (bases[i] & m));
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic g;
    logic [31:0] d, e, cache_exp;
    logic [31:0] addrs [7];
    int pos [6];
    addrs[0] = 32'h12AB_CDEF; addrs[1] = 32'h1300_0000; addrs[2] = 32'h0000_AB7C;
    addrs[3] = 32'h0000_AC00; addrs[4] = 32'h345F_FFFC; addrs[5] = 32'h3460_0000;
    addrs[6] = 32'h0000_0000;
    pos[0] = 8; pos[1] = 11; pos[2] = 12; pos[3] = 13; pos[4] = 14; pos[5] = 15;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk(rsp_valid == 0, "R13 rsp_valid", {31'h0, rsp_valid}, 0);
    chk({io_en, mem_en, mst_en, mwi_en, perr_en, serr_en} == 0, "R13 cmd outputs",
        {26'h0, io_en, mem_en, mst_en, mwi_en, perr_en, serr_en}, 0);
    chk(stat_bits == 0 && cache_line == 0, "R13 status/cache", {18'h0, stat_bits, cache_line}, 0);
    chk(bar_hit == 0, "R13 bar_hit", {26'h0, bar_hit}, 0);
    chk(hb_mst == 1, "R5 master enable forced at reset", {31'h0, hb_mst}, 1);

    // R1 identification
    rd(4'd0, d);  chk(d == {DEV, VEN}, "R1 dw0", d, {DEV, VEN});
    rd(4'd2, d);  chk(d == {CLS, REV}, "R1 dw2", d, {CLS, REV});
    rd(4'd3, d);  chk(d == 32'h0, "R1 dw3", d, 0);
    rd(4'd11, d); chk(d == {SID, SVID}, "R1 dw11", d, {SID, SVID});
    rd(4'd15, d); chk(d == {MLAT, MGNT, 8'h01, 8'h00}, "R1 dw15", d, {MLAT, MGNT, 8'h01, 8'h00});
    for (int k = 10; k < 15; k++) if (k != 11) begin
      rd(4'(k), d); chk(d == 0, "R1 reserved dword", d, 0);
    end

    // R2 claim sweep on reads
    for (int c = 0; c < 16; c++) for (int s = 0; s < 2; s++) begin
      access(4'(c), 1'(s), 4'd0, 4'hF, 32'h0, g, d);
      e = (c == 10 && s == 1) ? 1 : 0;
      chk(g == e[0], "R2 read claim", {31'h0, g}, e);
      if (e[0]) chk(d == {DEV, VEN}, "R2 claimed data", d, {DEV, VEN});
    end
    // R2 claim sweep on writes
    wr(4'd3, 4'hF, 32'h0);
    cache_exp = 0;
    for (int c = 0; c < 16; c++) for (int s = 0; s < 2; s++) begin
      access(4'(c), 1'(s), 4'd3, 4'b0001, 32'(c * 2 + s + 1), g, d);
      if (c == 11 && s == 1) cache_exp = 32'(c * 2 + s + 1);
      rd(4'd3, d);
      chk(d == cache_exp, "R2 write claim", d, cache_exp);
    end

    // R3 / R7 byte enable sweep on dw3
    for (int b = 0; b < 16; b++) begin
      wr(4'd3, 4'hF, 32'h0);
      wr(4'd3, 4'(b), 32'hA5C3_5A3C);
      rd(4'd3, d);
      e = 32'hA5C3_5A3C & lanes(4'(b)) & 32'h0000_FFFF;
      chk(d == e, "R3 R7 lanes dw3", d, e);
      chk(cache_line == e[7:0], "R7 cache_line port", {24'h0, cache_line}, {24'h0, e[7:0]});
    end
    wr(4'd15, 4'b0001, 32'hFFFF_FF6B);
    rd(4'd15, d); chk(d == {MLAT, MGNT, 8'h01, 8'h6B}, "R7 interrupt line", d, {MLAT, MGNT, 8'h01, 8'h6B});
    // R3 / R8 byte enable sweep on BAR2
    for (int b = 0; b < 16; b++) begin
      wr(4'd6, 4'hF, 32'h0);
      wr(4'd6, 4'(b), 32'hFFFF_FFFF);
      rd(4'd6, d);
      e = (lanes(4'(b)) & bmask(BARS[2])) | 32'h8;
      chk(d == e, "R3 R8 lanes BAR2", d, e);
    end

    // R4 command register
    wr(4'd1, 4'b0011, 32'hFFFF_FFFF);
    rd(4'd1, d); chk(d == 32'h0000_0157, "R4 command readback", d, 32'h157);
    chk({io_en, mem_en, mst_en, mwi_en, perr_en, serr_en} == 6'h3F, "R4 command pins",
        {26'h0, io_en, mem_en, mst_en, mwi_en, perr_en, serr_en}, 32'h3F);
    wr(4'd1, 4'b0001, 32'h0);
    rd(4'd1, d); chk(d == 32'h0000_0100, "R4 R3 lane0 only", d, 32'h100);
    wr(4'd1, 4'hF, 32'h0);
    rd(4'd1, d); chk(d == 0, "R4 cleared", d, 0);
    chk(hb_d[2] == 1'b1 && hb_mst == 1'b1, "R5 master enable forced", hb_d, 32'h4);

    // R6 status flags
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); stat_set = 6'(1 << k);
      @(negedge clk); stat_set = 0;
      chk(stat_bits == 6'(1 << k), "R6 set", {26'h0, stat_bits}, 32'(1 << k));
      rd(4'd1, d); chk(d == 32'(1 << (16 + pos[k])), "R6 readback", d, 32'(1 << (16 + pos[k])));
      wr(4'd1, 4'b0111, 32'hFFFF_FFFF & ~32'h0000_0157);
      chk(stat_bits == 6'(1 << k), "R6 lane3 disabled keeps flag", {26'h0, stat_bits}, 32'(1 << k));
      @(negedge clk);
      req_valid = 1; req_cmd = 4'b1011; req_sel = 1; req_dw = 4'd1; req_be = 4'b1000;
      req_wdata = 32'(1 << (16 + pos[k])); stat_set = 6'(1 << k);
      @(negedge clk); req_valid = 0; stat_set = 0;
      chk(stat_bits == 6'(1 << k), "R6 set wins over clear", {26'h0, stat_bits}, 32'(1 << k));
      wr(4'd1, 4'b1000, 32'(1 << (16 + pos[k])));
      chk(stat_bits == 0, "R6 write one clears", {26'h0, stat_bits}, 0);
    end

    // R8 / R9 BAR writable width
    for (int i = 0; i < 6; i++) begin
      wr(4'(4 + i), 4'hF, 32'hFFFF_FFFF);
      rd(4'(4 + i), d);
      e = (i < 3) ? (bmask(BARS[i]) | {28'h0, BARS[i][3:0]}) : 32'h0;
      chk(d == e, (i < 3) ? "R8 BAR width" : "R9 absent BAR", d, e);
    end

    // R9 R10 R11 decode sweep
    bases[0] = 32'h1200_0000; bases[1] = 32'h0000_AB00; bases[2] = 32'h3450_0000;
    for (int i = 0; i < 3; i++) wr(4'(4 + i), 4'hF, bases[i]);
    for (int i = 3; i < 6; i++) wr(4'(4 + i), 4'hF, 32'h0);
    for (int en = 0; en < 4; en++) begin
      wr(4'd1, 4'b0001, 32'(en));
      for (int c = 0; c < 16; c++) for (int a = 0; a < 7; a++) begin
        logic [5:0] ev;
        @(negedge clk); dec_cmd = 4'(c); dec_addr = addrs[a];
        #1;
        for (int i = 0; i < 6; i++) ev[i] = exp_hit(i, c, addrs[a], en[1], en[0]);
        chk(bar_hit == ev, "R10 R11 R9 bar_hit", {26'h0, bar_hit}, {26'h0, ev});
      end
    end
    dec_cmd = 0; dec_addr = 0;

    // R12 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_cmd = 4'b1010; req_sel = 1; req_dw = 4'd0; req_be = 4'hF;
    @(negedge clk);
    req_dw = 4'd2;
    chk(rsp_valid == 1 && rsp_data == {DEV, VEN}, "R12 first response", rsp_data, {DEV, VEN});
    for (int k = 0; k < 3; k++) begin
      chk(req_ready == 0, "R12 ready low while stalled", {31'h0, req_ready}, 0);
      @(negedge clk);
      chk(rsp_valid == 1 && rsp_data == {DEV, VEN}, "R12 held", rsp_data, {DEV, VEN});
    end
    rsp_ready = 1;
    #1;
    chk(req_ready == 1, "R12 ready follows rsp_ready", {31'h0, req_ready}, 1);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1 && rsp_data == {CLS, REV}, "R12 second response", rsp_data, {CLS, REV});
    @(negedge clk);
    chk(rsp_valid == 0, "R12 drained", {31'h0, rsp_valid}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule